// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter Pair

This block holds two 16-bit timer/counters (counter 0 and counter 1). Each one counts either a tick produced every twelve system clocks or falling edges seen on its own external count pin. Each counter has four width modes: a 13-bit count (an 8-bit count behind a 5-bit prescaler), a full 16-bit count, an 8-bit count that reloads itself, and a split mode. In split mode counter 0 becomes two independent 8-bit counters and counter 1 stands still. A run bit starts each counter. A gate bit can additionally make counting depend on the level of a matching gate pin. A cascade bit joins both counters into one 32-bit counter.

Each counter raises an overflow flag on its carry out, and the matching interrupt-acknowledge input clears that flag. Software reaches the counter bytes, the mode byte and the control byte through a small synchronous write port and a combinational read port.

Top module: `twin_timer`

## Requirements
- R1: Reset clears all four counter bytes, the mode byte, both run bits, the cascade bit and both overflow flags.
- R2: With the source-select bit at 0, a counter advances once per twelve system clocks while it is enabled. With the bit at 1, it advances only on external pin falls and ignores the twelve-clock tick.
- R3: Mode 00 increments the 13-bit value {high byte, low byte bits 4:0}. Low byte bits 7:5 keep their value, and the carry out of 0x1FFF sets the counter's flag.
- R4: Mode 01 increments the full 16-bit value {high, low}, and the wrap from 0xFFFF to 0x0000 sets the counter's flag.
- R5: Mode 10 increments only the low byte. When the low byte is at 0xFF, the next count loads it from the high byte, sets the flag and leaves the high byte unchanged.
- R6: When counter 0 is in mode 11, its low byte counts on counter 0's own enable and its carry sets flag 0. Its high byte counts the twelve-clock tick while run bit 1 is set, and its carry sets flag 1; counter 1's own carry then sets no flag. A counter 1 in mode 11 does not count.
- R7: With the gate bit at 0, the run bit alone enables counting. With the gate bit at 1, counting needs both the run bit and a high level on that counter's gate pin.
- R8: With the cascade bit set, {counter 1, counter 0} counts as one 32-bit value on counter 0's source, run and gate settings. Its wrap sets flag 1 only, and the mode fields are ignored.
- R9: A flag stays set until a one-cycle pulse on its acknowledge input clears it. A carry in the same cycle as the acknowledge wins.
- R10: An external pin is sampled every system clock. Each high-then-low pair of samples gives exactly one count, however long the pin then stays low.
- R11: A write to any byte of a counter takes effect at that clock edge and cancels that counter's count (and the flag it could set) in the same cycle. In cascade mode this applies to all four bytes together.
- R12: Register map, by address: 0 counter 0 low, 1 counter 0 high, 2 counter 1 low, 3 counter 1 high. Address 4 is the mode byte: bits 1:0 mode 0, bit 2 source 0, bit 3 gate 0, bits 5:4 mode 1, bit 6 source 1, bit 7 gate 1. Address 5 is the control byte: bit 0 run 0, bit 1 run 1, bit 2 cascade, bits 3 and 4 flags 0 and 1 (read only). All other bits and addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| extPin | input | 2 | External count pins, one per counter |
| gatePin | input | 2 | Gate level pins, one per counter |
| ackIn | input | 2 | Interrupt-acknowledge pulses that clear the flags |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from addr |
| ovfFlag | output | 2 | Overflow flags of counter 0 and counter 1 |

## Verification
A wrong mode decode or carry term shows up at the counter byte readback after the first count that crosses the affected boundary. A wrong flag source shows up at ovfFlag one clock after that count. Errors in the edge detector or the twelve-clock divider show as a count that is off by one within one pin pulse, or within a twelve-cycle window after the run bit is set. A broken write priority shows as a written value plus one on the very next read.

// File: rtl/twin_timer_pkg.sv
package twin_timer_pkg;
  parameter int BYTE_W = 8;
  parameter int PRE_W  = 5;
  parameter int ADDR_W = 3;

  typedef enum logic [1:0] {
    MODE_PRE    = 2'b00,
    MODE_WIDE   = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0]        tick;
    logic              hiTick;
    logic              cascade;
    tmode_t            mode0;
    tmode_t            mode1;
    logic [3:0]        wrByte;
    logic [BYTE_W-1:0] wrData;
  } strobe_t;

  typedef struct packed {
    logic [BYTE_W-1:0] lo;
    logic [BYTE_W-1:0] hi;
    logic              carry;
  } step_t;

  function automatic step_t stepPair(tmode_t m, logic [BYTE_W-1:0] lo, logic [BYTE_W-1:0] hi);
    step_t r;
    logic [BYTE_W+PRE_W-1:0] v13;
    logic [2*BYTE_W-1:0] v16;
    r.lo = lo;
    r.hi = hi;
    r.carry = 1'b0;
    v13 = {hi, lo[PRE_W-1:0]};
    v16 = {hi, lo};
    case (m)
      MODE_PRE: begin
        r.carry = &v13;
        v13 = v13 + (BYTE_W+PRE_W)'(1);
        r.hi = v13[BYTE_W+PRE_W-1:PRE_W];
        r.lo = {lo[BYTE_W-1:PRE_W], v13[PRE_W-1:0]};
      end
      MODE_WIDE: begin
        r.carry = &v16;
        v16 = v16 + (2*BYTE_W)'(1);
        r.hi = v16[2*BYTE_W-1:BYTE_W];
        r.lo = v16[BYTE_W-1:0];
      end
      MODE_RELOAD: begin
        r.carry = &lo;
        r.lo = r.carry ? hi : lo + BYTE_W'(1);
      end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/twin_timer_ctrl.sv
module twin_timer_ctrl
  import twin_timer_pkg::*;
#(
  parameter int DIV_RATIO = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        extPin,
  input  logic [1:0]        gatePin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output strobe_t           strb,
  output logic [BYTE_W-1:0] modeByte,
  output logic [2:0]        ctrlBits
);
  localparam int DIV_W = $clog2(DIV_RATIO);

  logic [DIV_W-1:0] divCnt;
  logic divTick;
  logic [1:0] smp, prv, fall, srcEv, enable;
  tmode_t mode [2];
  logic [1:0] ctSel, gateOn, run;
  logic cascade;
  logic [3:0] wrByte;
  logic wrC0, wrC1;

  assign divTick = (divCnt == DIV_W'(DIV_RATIO - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      smp <= '0;
      prv <= '0;
    end else begin
      divCnt <= divTick ? '0 : divCnt + DIV_W'(1);
      smp <= extPin;
      prv <= smp;
    end
  end

  assign fall = prv & ~smp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode[0] <= MODE_PRE;
      mode[1] <= MODE_PRE;
      ctSel <= '0;
      gateOn <= '0;
      run <= '0;
      cascade <= 1'b0;
    end else if (wrEn) begin
      if (addr == ADDR_W'(4)) begin
        mode[0]   <= tmode_t'(wrData[1:0]);
        ctSel[0]  <= wrData[2];
        gateOn[0] <= wrData[3];
        mode[1]   <= tmode_t'(wrData[5:4]);
        ctSel[1]  <= wrData[6];
        gateOn[1] <= wrData[7];
      end else if (addr == ADDR_W'(5)) begin
        run <= wrData[1:0];
        cascade <= wrData[2];
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_src
    assign srcEv[i]  = ctSel[i] ? fall[i] : divTick;
    assign enable[i] = run[i] & (~gateOn[i] | gatePin[i]) & srcEv[i];
  end

  for (genvar b = 0; b < 4; b++) begin : g_wr
    assign wrByte[b] = wrEn & (addr == ADDR_W'(b));
  end

  assign wrC0 = wrByte[0] | wrByte[1];
  assign wrC1 = wrByte[2] | wrByte[3];

  always_comb begin
    strb = '0;
    strb.cascade = cascade;
    strb.mode0 = mode[0];
    strb.mode1 = mode[1];
    strb.wrByte = wrByte;
    strb.wrData = wrData;
    if (cascade) begin
      strb.tick[0] = enable[0] & ~(wrC0 | wrC1);
    end else begin
      strb.tick[0] = enable[0] & ~wrC0;
      strb.hiTick  = (mode[0] == MODE_SPLIT) & run[1] & divTick & ~wrC0;
      strb.tick[1] = (mode[1] != MODE_SPLIT) & enable[1] & ~wrC1;
    end
  end

  assign modeByte = {gateOn[1], ctSel[1], mode[1], gateOn[0], ctSel[0], mode[0]};
  assign ctrlBits = {cascade, run};
endmodule

// File: rtl/twin_timer_dp.sv
module twin_timer_dp
  import twin_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        ackIn,
  output logic [BYTE_W-1:0] lo0,
  output logic [BYTE_W-1:0] hi0,
  output logic [BYTE_W-1:0] lo1,
  output logic [BYTE_W-1:0] hi1,
  output logic [1:0]        flag
);
  localparam int WIDE_W = 4 * BYTE_W;

  logic [BYTE_W-1:0] nLo0, nHi0, nLo1, nHi1;
  logic [1:0] setFlag;
  logic [WIDE_W-1:0] v32;
  step_t s0, s1;

  always_comb begin
    nLo0 = lo0; nHi0 = hi0; nLo1 = lo1; nHi1 = hi1;
    setFlag = '0;
    v32 = {hi1, lo1, hi0, lo0};
    s0 = stepPair(strb.mode0, lo0, hi0);
    s1 = stepPair(strb.mode1, lo1, hi1);
    if (strb.cascade) begin
      if (strb.tick[0]) begin
        setFlag[1] = &v32;
        v32 = v32 + WIDE_W'(1);
        {nHi1, nLo1, nHi0, nLo0} = v32;
      end
    end else begin
      if (strb.mode0 == MODE_SPLIT) begin
        if (strb.tick[0]) begin
          nLo0 = lo0 + BYTE_W'(1);
          setFlag[0] = &lo0;
        end
        if (strb.hiTick) begin
          nHi0 = hi0 + BYTE_W'(1);
          setFlag[1] = &hi0;
        end
      end else if (strb.tick[0]) begin
        nLo0 = s0.lo;
        nHi0 = s0.hi;
        setFlag[0] = s0.carry;
      end
      if (strb.tick[1]) begin
        nLo1 = s1.lo;
        nHi1 = s1.hi;
        if (strb.mode0 != MODE_SPLIT) setFlag[1] = s1.carry;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
    end else begin
      lo0 <= strb.wrByte[0] ? strb.wrData : nLo0;
      hi0 <= strb.wrByte[1] ? strb.wrData : nHi0;
      lo1 <= strb.wrByte[2] ? strb.wrData : nLo1;
      hi1 <= strb.wrByte[3] ? strb.wrData : nHi1;
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flag[i] <= 1'b0;
      else if (setFlag[i]) flag[i] <= 1'b1;
      else if (ackIn[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/twin_timer.sv
module twin_timer
  import twin_timer_pkg::*;
#(
  parameter int DIV_RATIO = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        extPin,
  input  logic [1:0]        gatePin,
  input  logic [1:0]        ackIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic [1:0]        ovfFlag
);
  strobe_t strb;
  logic [BYTE_W-1:0] modeByte, cntLo0, cntHi0, cntLo1, cntHi1;
  logic [2:0] ctrlBits;

  twin_timer_ctrl #(.DIV_RATIO(DIV_RATIO)) u_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .gatePin(gatePin),
    .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .strb(strb), .modeByte(modeByte), .ctrlBits(ctrlBits)
  );

  twin_timer_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ackIn(ackIn),
    .lo0(cntLo0), .hi0(cntHi0), .lo1(cntLo1), .hi1(cntHi1), .flag(ovfFlag)
  );

  always_comb begin
    case (addr)
      ADDR_W'(0): rdData = cntLo0;
      ADDR_W'(1): rdData = cntHi0;
      ADDR_W'(2): rdData = cntLo1;
      ADDR_W'(3): rdData = cntHi1;
      ADDR_W'(4): rdData = modeByte;
      ADDR_W'(5): rdData = BYTE_W'({ovfFlag, ctrlBits});
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/twin_timer_chk.sv
module twin_timer_chk
  import twin_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        ackIn,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [BYTE_W-1:0] wrData,
  input logic [1:0]        ovfFlag,
  input strobe_t           strb,
  input logic [BYTE_W-1:0] cntLo0,
  input logic [BYTE_W-1:0] cntLo1,
  input logic [BYTE_W-1:0] cntHi1
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |-> (ovfFlag == 2'b00 && cntLo0 == '0));

  p_flag0_source_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag[0]) |-> $past(strb.tick[0]));

  p_flag1_source_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag[1]) |-> $past(strb.tick[1] | strb.hiTick | (strb.cascade & strb.tick[0])));

  p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ackIn[0]) && !$past(strb.tick[0])) |-> !ovfFlag[0]);

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(0)) |=> cntLo0 == $past(wrData));

  p_split_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mode1 == MODE_SPLIT && !strb.cascade && !strb.wrByte[2] && !strb.wrByte[3])
      |=> $stable({cntHi1, cntLo1}));
endmodule

bind twin_timer twin_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .ackIn(ackIn), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .ovfFlag(ovfFlag), .strb(strb),
  .cntLo0(cntLo0), .cntLo1(cntLo1), .cntHi1(cntHi1)
);

// File: tb/tb_twin_timer.sv
module tb_twin_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] extPin = '0, gatePin = '0, ackIn = '0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic [1:0] ovfFlag;
  int nChk = 0, nFail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  twin_timer dut (.clk(clk), .rstN(rstN), .extPin(extPin), .gatePin(gatePin),
    .ackIn(ackIn), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .ovfFlag(ovfFlag));

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'(a); wrData = 8'(d);
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    addr = 3'(a);
    #1 v = int'(rdData);
  endtask

  task automatic expectReg(string req, int a, int exp);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic pulse(int i);
    @(negedge clk); extPin[i] = 1'b1;
    repeat (2) @(negedge clk);
    extPin[i] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    extPin = '0; gatePin = '0; ackIn = '0;
    repeat (2) @(negedge clk); rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset_r1();
    doReset();
    wr(0, 8'h5A); wr(4, 8'hFF); wr(5, 8'h07);
    doReset();
    for (int a = 0; a < 6; a++) expectReg("R1 register cleared", a, 0);
    check("R1 flags cleared", int'(ovfFlag), 0);
  endtask

  task automatic test_wide_r4();
    doReset();
    wr(4, 8'h01);
    wr(0, 8'hFE); wr(1, 8'hFF);
    wr(5, 8'h01);
    repeat (12) @(posedge clk);
    @(negedge clk);
    expectReg("R2 one tick per 12 clocks", 0, 8'hFF);
    check("R4 no flag before wrap", int'(ovfFlag[0]), 0);
    repeat (12) @(posedge clk);
    @(negedge clk);
    expectReg("R4 wrap low", 0, 8'h00);
    expectReg("R4 wrap high", 1, 8'h00);
    check("R4 flag on wrap", int'(ovfFlag[0]), 1);
  endtask

  task automatic test_prescale_r3();
    doReset();
    wr(4, 8'h04);
    wr(0, 8'hFF); wr(1, 8'h05);
    wr(5, 8'h01);
    pulse(0);
    expectReg("R3 low bits wrap, upper kept", 0, 8'hE0);
    expectReg("R3 high byte carry in", 1, 8'h06);
    check("R3 no flag", int'(ovfFlag[0]), 0);
    wr(0, 8'h3F); wr(1, 8'hFF);
    pulse(0);
    expectReg("R3 13-bit wrap low", 0, 8'h20);
    expectReg("R3 13-bit wrap high", 1, 8'h00);
    check("R3 flag on 13-bit wrap", int'(ovfFlag[0]), 1);
  endtask

  task automatic test_reload_r5();
    doReset();
    wr(4, 8'h60);
    wr(2, 8'hFE); wr(3, 8'h80);
    wr(5, 8'h02);
    pulse(1);
    expectReg("R5 low counts", 2, 8'hFF);
    check("R5 no flag yet", int'(ovfFlag[1]), 0);
    pulse(1);
    expectReg("R5 reloaded from high", 2, 8'h80);
    expectReg("R5 high unchanged", 3, 8'h80);
    check("R5 flag on reload", int'(ovfFlag[1]), 1);
  endtask

  task automatic test_split_r6();
    doReset();
    wr(4, 8'h07);
    wr(0, 8'hFF);
    wr(5, 8'h01);
    pulse(0);
    expectReg("R6 split low wraps", 0, 8'h00);
    check("R6 split low sets flag0 only", int'(ovfFlag), 1);
    wr(1, 8'hFF);
    wr(5, 8'h03);
    repeat (12) @(posedge clk);
    @(negedge clk);
    expectReg("R6 split high counts tick", 1, 8'h00);
    check("R6 split high sets flag1", int'(ovfFlag[1]), 1);
    wr(4, 8'h77);
    wr(2, 8'h10);
    pulse(1); pulse(1);
    expectReg("R6 counter1 stopped in mode 11", 2, 8'h10);
  endtask

  task automatic test_gate_r7();
    doReset();
    wr(4, 8'h0D);
    wr(5, 8'h01);
    pulse(0);
    expectReg("R7 gate pin low blocks", 0, 0);
    gatePin[0] = 1'b1;
    pulse(0);
    expectReg("R7 gate pin high counts", 0, 1);
  endtask

  task automatic test_cascade_r8();
    doReset();
    wr(4, 8'h04);
    wr(5, 8'h05);
    wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'h12); wr(3, 8'h00);
    pulse(0);
    expectReg("R8 carry into counter1", 2, 8'h13);
    expectReg("R8 counter0 wrapped", 1, 8'h00);
    check("R8 no flag on inner carry", int'(ovfFlag), 0);
    wr(2, 8'hFF); wr(3, 8'hFF); wr(0, 8'hFF); wr(1, 8'hFF);
    pulse(0);
    expectReg("R8 32-bit wrap", 3, 8'h00);
    check("R8 wrap sets flag1 only", int'(ovfFlag), 2);
    @(negedge clk); ackIn[1] = 1'b1;
    @(negedge clk); ackIn[1] = 1'b0;
    check("R9 ack clears flag1", int'(ovfFlag[1]), 0);
    expectReg("R12 control readback", 5, 8'h05);
  endtask

  task automatic test_edges_r10();
    doReset();
    wr(4, 8'h05);
    wr(5, 8'h01);
    repeat (36) @(negedge clk);
    expectReg("R2 external mode ignores tick", 0, 0);
    @(negedge clk); extPin[0] = 1'b1;
    repeat (3) @(negedge clk); extPin[0] = 1'b0;
    repeat (12) @(negedge clk);
    expectReg("R10 long low counts once", 0, 1);
    pulse(0); pulse(0);
    expectReg("R10 one count per fall", 0, 3);
    expectReg("R12 mode readback", 4, 8'h05);
  endtask

  task automatic test_write_r11();
    doReset();
    wr(4, 8'h05);
    wr(0, 8'hFF);
    wr(5, 8'h01);
    @(negedge clk); extPin[0] = 1'b1;
    repeat (3) @(negedge clk);
    extPin[0] = 1'b0;
    @(posedge clk);
    wr(0, 8'h40);
    repeat (3) @(negedge clk);
    expectReg("R11 write cancels count", 0, 8'h40);
    expectReg("R11 high byte untouched", 1, 8'h00);
    check("R11 no flag from cancelled carry", int'(ovfFlag[0]), 0);
  endtask

  initial begin
    test_reset_r1();
    test_wide_r4();
    test_prescale_r3();
    test_reload_r5();
    test_split_r6();
    test_gate_r7();
    test_cascade_r8();
    test_edges_r10();
    test_write_r11();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule